// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is one general-purpose 16-bit register that sits beside a free-running counter. A 4-bit mode field chooses how the register is used. In compare modes the counter is checked against the register. On each match the block can drive a pin low, drive it high or toggle it, and it can start that pin at a chosen level. In capture modes the register stores a snapshot of the counter value. The snapshot is taken on chosen edges of a pin, or on a trigger pulse from a neighbouring channel.

The counter value comes from outside the block. The block does not generate it, prescale it or route interrupts. Software writes the register and the mode field through simple write strobes. A sticky flag reports every match or capture, and the flag clears through a dedicated strobe. When the register is in use as the buffer of a paired register, a suppress input blocks both matching and capturing.

Top module: `tmr_cc_chan`

## Requirements
- R1: After reset the mode field is 0000, `gr_o` is 16'hFFFF, and `flag_o`, `pin_o` and `pin_oe_o` are 0.
- R2: In modes 0000 and 0100, `pin_oe_o` is 0. A counter match still sets `flag_o` one edge later.
- R3: Writing a mode with bit 3 = 0 and bits 1:0 not equal to 00 sets `pin_oe_o` and loads `pin_o` with mode bit 2 on the same edge. Bit 2 = 0 gives a low start and bit 2 = 1 gives a high start.
- R4: In an output mode, bits 1:0 select the match action: 01 drives the pin low, 10 drives it high, 11 toggles it. When `cnt_i` equals `gr_o` during a cycle, the action and the flag set both take effect on the clock edge that ends that cycle.
- R5: Mode 1000 captures on a rising pin edge only. Assume `pin_i` first changes level just before clock edge E. Then at edge E+2, `gr_o` loads the `cnt_i` value present just before that edge, and `flag_o` sets. A falling edge has no effect.
- R6: Mode 1001 captures on a falling pin edge only, with the R5 timing. A rising edge has no effect.
- R7: Modes 1010 and 1011 capture on both pin edges, with the R5 timing.
- R8: Modes 11xx capture the `cnt_i` value on the edge that samples `int_trig_i` high, and they ignore pin edges. Pin capture modes ignore `int_trig_i`.
- R9: While `pair_buf_i` is 1, neither compare nor capture happens. `gr_o`, `flag_o` and `pin_o` keep their values.
- R10: `flag_clr_i` clears `flag_o` on the next edge. If a match or capture happens on that same edge, the set wins.
- R11: In every capture mode (bit 3 = 1), `pin_oe_o` is 0.
- R12: `reg_wr_i` loads `reg_wdata_i` into `gr_o` on the next edge. If a capture happens on that same edge, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 16 | Current value of the free-running counter |
| mode_wr_i | input | 1 | Strobe that writes the mode field |
| mode_i | input | 4 | New mode code |
| reg_wr_i | input | 1 | Strobe that writes the general register |
| reg_wdata_i | input | 16 | Data for the register write |
| pair_buf_i | input | 1 | Register serves as a paired buffer; suppresses compare and capture |
| pin_i | input | 1 | Asynchronous capture pin |
| int_trig_i | input | 1 | Synchronous capture pulse from a neighbouring channel |
| flag_clr_i | input | 1 | Clears the match/capture flag |
| gr_o | output | 16 | General register contents |
| pin_o | output | 1 | Compare output level |
| pin_oe_o | output | 1 | Compare output enable |
| flag_o | output | 1 | Sticky match/capture flag |

## Verification
The hardest condition to reach from the ports is an exact counter match at a cycle the bench has chosen in advance. The bench also has to confirm that the pin does not move until the following edge. To get there, the bench drives the counter as a known function of the cycle number. It then writes the register with the counter value of a target cycle a few cycles ahead, so both the pre-match and post-match states land on cycles it can name. Pin captures work the same way: the bench knows the two-stage synchronizer delay and predicts the exact counter value that gets latched. Toggle actions get two matches in a row, and capture/compare suppression is checked while a real edge or match arrives.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } cmp_act_e;

    typedef struct packed {
        logic     cmp_en;
        logic     out_en;
        logic     init_lvl;
        cmp_act_e act;
        logic     pin_cap;
        logic     cap_rise;
        logic     cap_fall;
        logic     int_cap;
    } mode_dec_t;

    typedef struct packed {
        logic pin;
    } pout_st_t;

endpackage

// File: rtl/tmr_cc_decode.sv
module tmr_cc_decode
    import tmr_cc_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output mode_dec_t         dec_o
);

    always_comb begin
        dec_o = '0;
        if (!mode_i[3]) begin
            dec_o.cmp_en   = 1'b1;
            dec_o.out_en   = (mode_i[1:0] != 2'b00);
            dec_o.init_lvl = mode_i[2];
            dec_o.act      = cmp_act_e'(mode_i[1:0]);
        end else if (!mode_i[2]) begin
            dec_o.pin_cap  = 1'b1;
            dec_o.cap_rise = mode_i[1] | ~mode_i[0];
            dec_o.cap_fall = mode_i[1] | mode_i[0];
        end else begin
            dec_o.int_cap  = 1'b1;
        end
    end

endmodule

// File: rtl/tmr_cc_insync.sv
module tmr_cc_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb begin
                st_d      = st_q;
                st_d.sync = {st_q.sync[STAGES-2:0], pin_i};
                st_d.last = st_q.sync[TOP];
            end
        end else begin : g_single
            always_comb begin
                st_d      = st_q;
                st_d.sync = pin_i;
                st_d.last = st_q.sync[TOP];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sync[TOP] & ~st_q.last;
    assign fall_o = ~st_q.sync[TOP] & st_q.last;

    AST_EDGE_FROM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R5

endmodule

// File: rtl/tmr_cc_pinout.sv
module tmr_cc_pinout
    import tmr_cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_wr_i,
    input  mode_dec_t wr_dec_i,
    input  mode_dec_t cur_dec_i,
    input  logic      match_i,
    output logic      pin_o
);

    pout_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_wr_i && wr_dec_i.out_en) begin
            st_d.pin = wr_dec_i.init_lvl;
        end else if (match_i && cur_dec_i.out_en) begin
            unique case (cur_dec_i.act)
                ACT_LOW:    st_d.pin = 1'b0;
                ACT_HIGH:   st_d.pin = 1'b1;
                ACT_TOGGLE: st_d.pin = ~st_q.pin;
                default:    st_d.pin = st_q.pin;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_o = st_q.pin;

    AST_INIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i && wr_dec_i.out_en && !wr_dec_i.init_lvl) |=> !pin_o); // R3
    AST_INIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i && wr_dec_i.out_en && wr_dec_i.init_lvl) |=> pin_o); // R3
    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wr_i && match_i && cur_dec_i.out_en && cur_dec_i.act == ACT_TOGGLE)
        |=> pin_o != $past(pin_o)); // R4
    AST_NO_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wr_i && !match_i) |=> $stable(pin_o)); // R9

endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan
    import tmr_cc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              mode_wr_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              reg_wr_i,
    input  logic [CNT_W-1:0]  reg_wdata_i,
    input  logic              pair_buf_i,
    input  logic              pin_i,
    input  logic              int_trig_i,
    input  logic              flag_clr_i,
    output logic [CNT_W-1:0]  gr_o,
    output logic              pin_o,
    output logic              pin_oe_o,
    output logic              flag_o
);

    localparam logic [CNT_W-1:0] GR_RESET = '1;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  gr;
        logic              flag;
    } chan_st_t;

    chan_st_t  st_d, st_q;
    mode_dec_t cur_dec, wr_dec;
    logic      pin_rise, pin_fall;
    logic      match_evt, cap_evt, set_evt;

    tmr_cc_decode u_cur_dec (
        .mode_i (st_q.mode),
        .dec_o  (cur_dec)
    );

    tmr_cc_decode u_wr_dec (
        .mode_i (mode_i),
        .dec_o  (wr_dec)
    );

    tmr_cc_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    always_comb begin
        match_evt = !pair_buf_i && cur_dec.cmp_en && (cnt_i == st_q.gr);
        cap_evt   = !pair_buf_i &&
                    ((cur_dec.pin_cap && ((pin_rise && cur_dec.cap_rise) ||
                                          (pin_fall && cur_dec.cap_fall))) ||
                     (cur_dec.int_cap && int_trig_i));
        set_evt   = match_evt || cap_evt;
    end

    always_comb begin
        st_d = st_q;
        if (mode_wr_i) st_d.mode = mode_i;
        if (cap_evt)       st_d.gr = cnt_i;
        else if (reg_wr_i) st_d.gr = reg_wdata_i;
        if (set_evt)         st_d.flag = 1'b1;
        else if (flag_clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= '0;
            st_q.gr   <= GR_RESET;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    tmr_cc_pinout u_pout (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr_i (mode_wr_i),
        .wr_dec_i  (wr_dec),
        .cur_dec_i (cur_dec),
        .match_i   (match_evt),
        .pin_o     (pin_o)
    );

    assign gr_o     = st_q.gr;
    assign flag_o   = st_q.flag;
    assign pin_oe_o = cur_dec.out_en;

    AST_OE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode[3] |-> !pin_oe_o); // R11
    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> gr_o == $past(cnt_i)); // R5
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_buf_i && !reg_wr_i) |=> $stable(gr_o)); // R9
    AST_BUF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_buf_i && !flag_o) |=> !flag_o); // R9
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !set_evt) |=> !flag_o); // R10
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_o); // R10
    AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !cap_evt) |=> gr_o == $past(reg_wdata_i)); // R12

endmodule

// File: tb/tb_tmr_cc_chan.sv
module tb_tmr_cc_chan;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int K_REG = 0, K_FLAG = 1, K_PIN = 2, K_OE = 3;

    typedef struct {
        int          cyc;
        int          kind;
        logic [15:0] val;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_i = '0;
    logic        mode_wr_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic        pair_buf_i = 1'b0;
    logic        pin_i = 1'b0;
    logic        int_trig_i = 1'b0;
    logic        flag_clr_i = 1'b0;
    logic [15:0] gr_o;
    logic        pin_o, pin_oe_o, flag_o;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    exp_t sb[$];
    logic [15:0] exp_reg = 16'hFFFF;
    logic        exp_pin = 1'b0;

    tmr_cc_chan dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .mode_wr_i(mode_wr_i),
        .mode_i(mode_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .pair_buf_i(pair_buf_i), .pin_i(pin_i), .int_trig_i(int_trig_i),
        .flag_clr_i(flag_clr_i), .gr_o(gr_o), .pin_o(pin_o),
        .pin_oe_o(pin_oe_o), .flag_o(flag_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] cval(int j);
        return 16'(j * 5 + 100);
    endfunction

    always @(negedge clk) cnt_i = cval(cyc);

    // monitor: pops expected items whose cycle has arrived
    always @(posedge clk) begin
        cyc = cyc + 1;
        #(CLK_PERIOD/4);
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            logic [15:0] act;
            e = sb.pop_front();
            case (e.kind)
                K_REG:   act = gr_o;
                K_FLAG:  act = {15'd0, flag_o};
                K_PIN:   act = {15'd0, pin_o};
                default: act = {15'd0, pin_oe_o};
            endcase
            n_chk++;
            if (act !== e.val || e.cyc != cyc) begin
                n_bad++;
                $display("FAIL %s cycle %0d kind %0d actual %h expected %h",
                         e.req, e.cyc, e.kind, act, e.val);
            end
        end
    end

    task automatic push(int c, int kind, logic [15:0] v, string req);
        exp_t e;
        e.cyc = c; e.kind = kind; e.val = v; e.req = req;
        sb.push_back(e);
    endtask

    task automatic step();
        @(negedge clk);
        mode_wr_i  = 1'b0;
        reg_wr_i   = 1'b0;
        flag_clr_i = 1'b0;
        int_trig_i = 1'b0;
    endtask

    task automatic run_to(int c);
        while (cyc < c) step();
    endtask

    task automatic op_mode(logic [3:0] m, string req);
        int k;
        logic oe;
        step();
        mode_i = m; mode_wr_i = 1'b1; k = cyc;
        oe = !m[3] && (m[1:0] != 2'b00);
        push(k + 1, K_OE, {15'd0, oe}, req);
        if (oe) begin
            exp_pin = m[2];
            push(k + 1, K_PIN, {15'd0, exp_pin}, req);
        end
        run_to(k + 1);
    endtask

    task automatic op_clr();
        int k;
        step();
        flag_clr_i = 1'b1; k = cyc;
        push(k + 1, K_FLAG, 16'd0, "R10");
        run_to(k + 1);
    endtask

    // arm a match in 3 cycles; check before and after the match edge
    task automatic cmp_hit(logic pin_after, logic hit, logic chk_pin, string req);
        int k, t;
        logic [15:0] v;
        step();
        k = cyc; t = k + 3; v = cval(t);
        reg_wr_i = 1'b1; reg_wdata_i = v; exp_reg = v;
        push(k + 1, K_REG, v, "R12");
        if (chk_pin) push(t, K_PIN, {15'd0, exp_pin}, req);
        push(t, K_FLAG, 16'd0, req);
        if (hit && chk_pin) exp_pin = pin_after;
        if (chk_pin) push(t + 1, K_PIN, {15'd0, exp_pin}, req);
        push(t + 1, K_FLAG, {15'd0, hit}, req);
        run_to(t + 1);
    endtask

    task automatic cap_pin(logic lvl, logic hit, string req);
        int k;
        step();
        pin_i = lvl; k = cyc;
        push(k + 2, K_FLAG, 16'd0, req);
        if (hit) exp_reg = cval(k + 2);
        push(k + 3, K_REG, exp_reg, req);
        push(k + 3, K_FLAG, {15'd0, hit}, req);
        run_to(k + 3);
    endtask

    task automatic cap_int(logic hit, string req);
        int k;
        step();
        int_trig_i = 1'b1; k = cyc;
        if (hit) exp_reg = cval(k);
        push(k + 1, K_REG, exp_reg, req);
        push(k + 1, K_FLAG, {15'd0, hit}, req);
        push(k + 2, K_FLAG, {15'd0, hit}, req);
        run_to(k + 2);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        // R1 reset state
        push(2, K_REG, 16'hFFFF, "R1");
        push(2, K_FLAG, 16'd0, "R1");
        push(2, K_PIN, 16'd0, "R1");
        push(2, K_OE, 16'd0, "R1");
        run_to(3);
        rst_n = 1'b1;
        push(5, K_OE, 16'd0, "R1");
        run_to(5);

        // R3 initial levels
        op_mode(4'b0001, "R3");
        op_mode(4'b0101, "R3");
        op_mode(4'b0111, "R3");
        op_mode(4'b0011, "R3");

        // R4 match actions
        op_mode(4'b0010, "R4");
        cmp_hit(1'b1, 1'b1, 1'b1, "R4");
        op_clr();
        op_mode(4'b0101, "R4");
        cmp_hit(1'b0, 1'b1, 1'b1, "R4");
        op_clr();
        op_mode(4'b0011, "R4");
        cmp_hit(1'b1, 1'b1, 1'b1, "R4");
        op_clr();
        cmp_hit(1'b0, 1'b1, 1'b1, "R4");
        op_clr();

        // R2 output disabled but compare still flags
        op_mode(4'b0000, "R2");
        cmp_hit(1'b0, 1'b1, 1'b0, "R2");
        op_clr();
        op_mode(4'b0100, "R2");
        cmp_hit(1'b0, 1'b1, 1'b0, "R2");
        op_clr();

        // R9 compare suppressed in buffer use
        op_mode(4'b0010, "R9");
        step(); pair_buf_i = 1'b1;
        cmp_hit(1'b1, 1'b0, 1'b1, "R9");
        step(); pair_buf_i = 1'b0;

        // R5 / R11 rising capture
        op_mode(4'b1000, "R11");
        cap_pin(1'b1, 1'b1, "R5");
        op_clr();
        cap_pin(1'b0, 1'b0, "R5");
        cap_int(1'b0, "R8");

        // R6 falling capture
        op_mode(4'b1001, "R6");
        cap_pin(1'b1, 1'b0, "R6");
        cap_pin(1'b0, 1'b1, "R6");
        op_clr();

        // R7 both edges
        op_mode(4'b1010, "R7");
        cap_pin(1'b1, 1'b1, "R7");
        op_clr();
        op_mode(4'b1011, "R7");
        cap_pin(1'b0, 1'b1, "R7");
        op_clr();

        // R8 internal trigger, pin ignored
        op_mode(4'b1100, "R8");
        cap_pin(1'b1, 1'b0, "R8");
        cap_int(1'b1, "R8");
        op_clr();
        op_mode(4'b1111, "R8");
        cap_int(1'b1, "R8");
        op_clr();

        // R9 capture suppressed in buffer use
        op_mode(4'b1010, "R9");
        step(); pair_buf_i = 1'b1;
        cap_pin(1'b0, 1'b0, "R9");
        step(); pair_buf_i = 1'b0;

        run_to(cyc + 3);
        if (sb.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R1 scoreboard left %0d expected 0", sb.size());
        end
        finish_run();
    end

endmodule